// File: doc/BRIEF.md
# Status Sense Write-Back Sequencer

This block runs the status-sense step of an I/O channel program. On a start pulse it strobes the attached device controller for status, with the channel-select line asserted alongside the strobe. It latches the word the device places on its data lines when the device acknowledges, and then writes that word back to memory.

The destination is the address-word slot of the order being executed. The fetch step has already moved the I/O program counter past that order, so the sequencer steps the counter back by one before it issues the address. The memory write has two phases, each a valid/ready handshake. The address phase carries the counter value and the bank number, and the counter advances again once the address is accepted. The data phase carries the latched status word. The bank comes either from a bank register input or is forced to zero by a control input, and it is sampled at start.

A one-cycle done pulse marks the end, after which the channel goes back to fetching program words. Back-pressure rules for the memory port:
- A valid, once raised, stays high with its payload stable until its ready is seen high at a clock edge.
- The data phase never starts before the address has been accepted.
- Either ready may stay low for any number of cycles, for example while a higher-priority module holds the port.

Top module: `sense_wb_top`

## Requirements
- R1: After reset the block is idle: `dev_stb`, `dev_sel`, `mem_req`, `addr_valid`, `data_valid`, `done` and `busy` are all 0.
- R2: A `start` pulse seen while idle raises `dev_stb` and `dev_sel` together in the next cycle, and `busy` goes high. Both stay high until `dev_ack` is sampled high.
- R3: The cycle after `dev_ack` is sampled high, `dev_stb` and `dev_sel` drop. The sequencer then does not advance while `dev_ack` stays high. `addr_valid` rises exactly two cycles after `dev_ack` is first sampled low.
- R4: The value on `dev_data` at the edge where `dev_ack` is first sampled high is the word later written. Changes on `dev_data` after that edge have no effect. Captures alternate between two internal buffers.
- R5: The write address `mem_addr` equals the `pc_in` value sampled at start minus one, modulo 2^AW. An input of 0 therefore gives all ones.
- R6: `mem_bank` is 0 when `bank_zero` was 1 at start; otherwise it is the `bank_reg` value sampled at start.
- R7: `addr_valid` and `mem_addr` hold stable until `addr_ready` is sampled high. `data_valid` rises in the next cycle and `addr_valid` falls. `mem_req` is high throughout both phases.
- R8: Once the address is accepted, `pc_out` equals the `pc_in` value sampled at start, which is the rewound value plus one.
- R9: `data_valid` and `mem_wdata` hold stable until `data_ready` is sampled high, however long that takes.
- R10: `done` is high for exactly one cycle, the cycle after the data handshake. `busy`, `data_valid` and `mem_req` are low in that same cycle, and a new `start` is accepted from then on.
- R11: A `start` pulse while busy is ignored: the address, bank and data of the sense in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sense sequence (from the fetch step) |
| pc_in | input | AW | I/O program counter value after the fetch step |
| bank_reg | input | BW | Bank register value |
| bank_zero | input | 1 | 1 forces bank 0 as destination |
| dev_stb | output | 1 | Status strobe to device controller |
| dev_sel | output | 1 | Channel select to device controller |
| dev_ack | input | 1 | Device acknowledge |
| dev_data | input | DW | Device data lines |
| mem_req | output | 1 | Memory write request |
| addr_valid | output | 1 | Address phase valid |
| addr_ready | input | 1 | Address grant |
| mem_addr | output | AW | Write address |
| mem_bank | output | BW | Destination bank |
| data_valid | output | 1 | Data phase valid |
| data_ready | input | 1 | Data grant |
| mem_wdata | output | DW | Status word being written |
| pc_out | output | AW | I/O program counter held by the block |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The bench aims at counter wrap: a `pc_in` of zero must give an all-ones address and return to zero. A design that rewinds at the wrong point, or forgets to increment after the address grant, shows a wrong address or a wrong `pc_out`. The bench changes `dev_data` right after the acknowledge edge, so a design that samples late writes the garbage word. It holds `dev_ack` high for several cycles; a design that advances early raises `addr_valid` too soon. Long stalls on both ready inputs catch payloads that drift or phases that overlap. A `start` pulse in mid-sequence catches a design that restarts, and a reset during the data phase checks the return to idle.

// File: rtl/sense_wb_pkg.sv
package sense_wb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STROBE = 3'd1,
    ST_ACKLOW = 3'd2,
    ST_REWIND = 3'd3,
    ST_ADDR   = 3'd4,
    ST_DATA   = 3'd5
  } sense_st_e;
endpackage

// File: rtl/sense_wb_fsm.sv
module sense_wb_fsm
  import sense_wb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      dev_ack,
  input  logic      addr_ready,
  input  logic      data_ready,
  output sense_st_e state,
  output logic      cap_en,
  output logic      pc_load,
  output logic      pc_dec,
  output logic      pc_inc,
  output logic      done
);
  sense_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start)      nxt = ST_STROBE;
      ST_STROBE: if (dev_ack)    nxt = ST_ACKLOW;
      ST_ACKLOW: if (!dev_ack)   nxt = ST_REWIND;
      ST_REWIND:                 nxt = ST_ADDR;
      ST_ADDR:   if (addr_ready) nxt = ST_DATA;
      ST_DATA:   if (data_ready) nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  assign cap_en  = (state == ST_STROBE) && dev_ack;
  assign pc_load = (state == ST_IDLE) && start;
  assign pc_dec  = (state == ST_REWIND);
  assign pc_inc  = (state == ST_ADDR) && addr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_DATA) && data_ready;
    end
  end

  // R3
  no_early_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACKLOW && dev_ack) |=> (state == ST_ACKLOW));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));
endmodule

// File: rtl/sense_wb_statbuf.sv
module sense_wb_statbuf #(
  parameter int DW    = 16,
  parameter int NBUF  = 2,
  localparam int SELW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0]   bufs [NBUF];
  logic [SELW-1:0] wr_sel;
  logic [SELW-1:0] rd_sel;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n)                                   bufs[g] <= '0;
      else if (cap_en && wr_sel == SELW'(g))        bufs[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel <= '0;
      rd_sel <= '0;
    end else if (cap_en) begin
      rd_sel <= wr_sel;
      wr_sel <= (wr_sel == SELW'(NBUF - 1)) ? '0 : wr_sel + 1'b1;
    end
  end

  assign dout = bufs[rd_sel];

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (dout == $past(din)));
endmodule

// File: rtl/sense_wb_pcunit.sv
module sense_wb_pcunit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic          inc,
  input  logic [AW-1:0] pc_in,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= '0;
    else if (load) pc_q <= pc_in;
    else if (dec)  pc_q <= pc_q - 1'b1;
    else if (inc)  pc_q <= pc_q + 1'b1;
  end

  // R5
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (pc_q == $past(pc_q) - 1'b1));
  // R8
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !dec) |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/sense_wb_top.sv
module sense_wb_top
  import sense_wb_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pc_in,
  input  logic [BW-1:0] bank_reg,
  input  logic          bank_zero,
  output logic          dev_stb,
  output logic          dev_sel,
  input  logic          dev_ack,
  input  logic [DW-1:0] dev_data,
  output logic          mem_req,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_bank,
  output logic          data_valid,
  input  logic          data_ready,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] pc_out,
  output logic          done,
  output logic          busy
);
  sense_st_e     state;
  logic          cap_en, pc_load, pc_dec, pc_inc;
  logic [BW-1:0] bank_q;
  logic [DW-1:0] stat_word;

  sense_wb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dev_ack    (dev_ack),
    .addr_ready (addr_ready),
    .data_ready (data_ready),
    .state      (state),
    .cap_en     (cap_en),
    .pc_load    (pc_load),
    .pc_dec     (pc_dec),
    .pc_inc     (pc_inc),
    .done       (done)
  );

  sense_wb_statbuf #(.DW(DW), .NBUF(2)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .din    (dev_data),
    .dout   (stat_word)
  );

  sense_wb_pcunit #(.AW(AW)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pc_load),
    .dec   (pc_dec),
    .inc   (pc_inc),
    .pc_in (pc_in),
    .pc_q  (pc_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       bank_q <= '0;
    else if (pc_load) bank_q <= bank_zero ? '0 : bank_reg;
  end

  assign dev_stb    = (state == ST_STROBE);
  assign dev_sel    = (state == ST_STROBE);
  assign addr_valid = (state == ST_ADDR);
  assign data_valid = (state == ST_DATA);
  assign mem_req    = addr_valid | data_valid;
  assign mem_addr   = pc_out;
  assign mem_bank   = bank_q;
  assign mem_wdata  = stat_word;
  assign busy       = (state != ST_IDLE);

  // R2
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb |-> dev_sel);
  // R3
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stb && dev_ack) |=> !dev_stb);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(mem_addr) && $stable(mem_bank)));
  // R7
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready) |=> (data_valid && !addr_valid));
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !data_ready) |=> (data_valid && $stable(mem_wdata)));
  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_valid, data_valid, dev_stb}));
endmodule

// File: tb/sense_wb_top_tb.sv
module sense_wb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int BW = 4;

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [DW-1:0] data;
    logic [BW-1:0] bank;
    logic          bzero;
    logic [3:0]    ack_wait;
    logic [3:0]    ack_hold;
    logic [3:0]    agnt_dly;
    logic [3:0]    dgnt_dly;
    logic          poke;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 16'hA5C3, 4'h3, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0},
    '{16'h0000, 16'h1234, 4'h7, 1'b1, 4'd2, 4'd3, 4'd1, 4'd5, 1'b0},
    '{16'hFFFF, 16'hFFFF, 4'hF, 1'b0, 4'd5, 4'd1, 4'd7, 4'd0, 1'b1},
    '{16'h4001, 16'h0000, 4'h9, 1'b1, 4'd1, 4'd0, 4'd0, 4'd9, 1'b0},
    '{16'h8000, 16'h5A5A, 4'h1, 1'b0, 4'd3, 4'd4, 4'd3, 4'd2, 1'b1},
    '{16'h0001, 16'hC001, 4'hA, 1'b0, 4'd0, 4'd2, 4'd12, 4'd12, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic [BW-1:0] bank_reg = '0;
  logic          bank_zero = 1'b0;
  logic          dev_ack = 1'b0;
  logic [DW-1:0] dev_data = '0;
  logic          addr_ready = 1'b0;
  logic          data_ready = 1'b0;
  logic          dev_stb, dev_sel, mem_req, addr_valid, data_valid, done, busy;
  logic [AW-1:0] mem_addr, pc_out;
  logic [BW-1:0] mem_bank;
  logic [DW-1:0] mem_wdata;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sense_wb_top #(.DW(DW), .AW(AW), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
    .bank_reg(bank_reg), .bank_zero(bank_zero),
    .dev_stb(dev_stb), .dev_sel(dev_sel), .dev_ack(dev_ack), .dev_data(dev_data),
    .mem_req(mem_req), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .mem_addr(mem_addr), .mem_bank(mem_bank), .data_valid(data_valid),
    .data_ready(data_ready), .mem_wdata(mem_wdata), .pc_out(pc_out),
    .done(done), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_sense(input vec_t v, input int idx);
    logic [AW-1:0] exp_addr;
    logic [BW-1:0] exp_bank;
    exp_addr = v.pc - 1'b1;
    exp_bank = v.bzero ? '0 : v.bank;
    @(negedge clk);
    start = 1'b1; pc_in = v.pc; bank_reg = v.bank; bank_zero = v.bzero;
    @(negedge clk);
    start = 1'b0; pc_in = ~v.pc; bank_reg = ~v.bank; bank_zero = ~v.bzero;
    chk("R2 strobe+sel", {30'd0, dev_stb, dev_sel}, 32'h3);
    chk("R2 busy", busy, 1);
    for (int i = 0; i < v.ack_wait; i++) begin
      if (v.poke && i == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 strobe held", dev_stb, 1);
    end
    dev_ack = 1'b1; dev_data = v.data;
    @(negedge clk);
    dev_data = ~v.data;
    chk("R3 strobe dropped", {30'd0, dev_stb, dev_sel}, 0);
    for (int i = 0; i < v.ack_hold; i++) begin
      if (v.poke) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R3 no advance while ack high", mem_req, 0);
    end
    dev_ack = 1'b0;
    @(negedge clk);
    chk("R3 addr not yet", addr_valid, 0);
    @(negedge clk);
    chk("R3 addr_valid timing", addr_valid, 1);
    chk("R7 mem_req addr phase", mem_req, 1);
    chk("R5 address", mem_addr, exp_addr);
    chk("R6 bank", mem_bank, exp_bank);
    for (int i = 0; i < v.agnt_dly; i++) begin
      if (v.poke) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 addr held", {addr_valid, mem_addr}, {1'b1, exp_addr});
      chk("R11 bank unchanged", mem_bank, exp_bank);
    end
    addr_ready = 1'b1;
    @(negedge clk);
    addr_ready = 1'b0;
    chk("R7 phase switch", {30'd0, addr_valid, data_valid}, 1);
    chk("R7 mem_req data phase", mem_req, 1);
    chk("R8 pc restored", pc_out, v.pc);
    chk("R4 status word", mem_wdata, v.data);
    for (int i = 0; i < v.dgnt_dly; i++) begin
      @(negedge clk);
      chk("R9 data held", {data_valid, mem_wdata}, {1'b1, v.data});
      chk("R10 no early done", done, 0);
    end
    data_ready = 1'b1;
    @(negedge clk);
    data_ready = 1'b0;
    chk("R10 done pulse", {28'd0, done, busy, data_valid, mem_req}, 32'h8);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R8 pc after done", pc_out, v.pc);
    if (idx < 0) $display("unreachable");
  endtask

  initial begin
    tick(3);
    chk("R1 reset outputs",
        {25'd0, dev_stb, dev_sel, mem_req, addr_valid, data_valid, done, busy}, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 idle after release", {30'd0, busy, mem_req}, 0);

    for (int k = 0; k < NV; k++) run_sense(VEC[k], k);

    // R10: back-to-back start right after done
    run_sense(VEC[0], 0);
    run_sense(VEC[1], 1);

    // R1: reset in mid data phase returns to idle
    @(negedge clk);
    start = 1'b1; pc_in = 16'h0020; bank_zero = 1'b0; bank_reg = 4'h2;
    @(negedge clk);
    start = 1'b0; dev_ack = 1'b1; dev_data = 16'h7777;
    @(negedge clk);
    dev_ack = 1'b0;
    tick(2);
    addr_ready = 1'b1;
    @(negedge clk);
    addr_ready = 1'b0;
    chk("R7 data phase before reset", data_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-sequence",
        {25'd0, dev_stb, dev_sel, mem_req, addr_valid, data_valid, done, busy}, 0);
    rst_n = 1'b1;
    // R4: buffers still capture correctly after reset
    run_sense(VEC[3], 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule